// File: doc/BRIEF.md
# Exception Entry and PC Sequencer

This block keeps the fetch address pair of a 32-bit RISC core that executes one instruction after every branch (a single delay slot). Each retired instruction moves the current fetch address to the held next address. The next address becomes either the sequential successor or a branch or jump target that the execute stage presents with the retiring instruction. When the core raises an exception, or when a periodic interrupt poll finds an enabled request, the block redirects fetch to one of two handler entry points. It records the interrupted address, whether that address sits in a delay slot, the cause code and the interrupt source number.

The interrupt poll is not continuous. A counter of retired instructions opens a poll window only on every 64th retirement. In that window the enabled sources are scanned in a fixed index order, and the lowest-numbered one is served. A source that is pending between polls waits for the next window.

Top module: `exc_pc_seq`

## Requirements
- R1: In a clock cycle with `rst` high, the fetch address becomes 0xBFC00000, the next address becomes 0xBFC00004, `taken_o` becomes 0 and the retirement count becomes zero.
- R2: A retirement with no exception request and no taken branch loads the fetch address with the old next address, and the next address with the old next address plus 4.
- R3: A retirement with `br_take_i` high loads the fetch address with the old next address, which is the delay slot, and the next address with `br_target_i`. Without `retire_i`, `br_take_i` has no effect.
- R4: An exception request redirects to 0x80000000 when `exc_refill_i` is high, and to 0x80000080 otherwise. The next address becomes the handler address plus 4.
- R5: On every redirection, `taken_o` pulses high for exactly one cycle. `epc_o` holds the fetch address that was current at the redirection. `code_o` holds the 4-bit cause: the value of `exc_code_i` for an exception (1 TLB modified, 2/3 TLB load/store miss, 4/5 address error load/store, 6/7 bus error fetch/data, 8 syscall, 9 breakpoint, 10 reserved instruction, 11 coprocessor unusable, 12 overflow), and 0 for an external interrupt.
- R6: `bd_o` is 1 exactly when, at the redirection, the next address differed from the interrupted address plus 4.
- R7: An exception request takes priority over a simultaneous retirement and branch. The branch target is discarded, and that retirement is not counted.
- R8: Interrupt requests are examined only on the retirement that completes each group of 64 counted retirements since reset. Requests present at any other time cause no redirection.
- R9: In a poll, only sources whose `irq_mask_i` bit is 1 are considered, and the lowest index wins. The interrupt uses the state after that retirement: `epc_o` is the address just advanced to, `irq_num_o` is the index, and the handler is 0x80000080. With no enabled source pending, the retirement proceeds as in R2/R3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| retire_i | input | 1 | An instruction completes this cycle |
| br_take_i | input | 1 | The retiring instruction redirects the address after its delay slot |
| br_target_i | input | 32 | Branch or jump target |
| exc_req_i | input | 1 | Exception raised by the current instruction |
| exc_refill_i | input | 1 | The exception is a user TLB refill miss |
| exc_code_i | input | 4 | Cause code of the exception |
| irq_pend_i | input | NSRC | Pending requests, one per source |
| irq_mask_i | input | NSRC | Per-source enable |
| pc_o | output | 32 | Current fetch address |
| npc_o | output | 32 | Next fetch address |
| epc_o | output | 32 | Saved interrupted address |
| bd_o | output | 1 | Interrupted address was in a delay slot |
| code_o | output | 4 | Recorded cause code |
| irq_num_o | output | IW | Recorded interrupt source index |
| taken_o | output | 1 | Redirection happened in the previous cycle |

## Verification
The assertions check these properties on every cycle: handler address choice, the plus-4 next address after a redirection, the saved address and delay flag against the previous cycle, exception precedence over a branch, and that an interrupt is served only in a poll window and only for the lowest enabled pending source. The bench scenarios are what show the full address sequence through branches and delay slots, that requests between polls are really ignored, the behaviour of masked-only polls, and the exact cadence when exceptions are mixed into the retirement count.

// File: rtl/exc_seq_pkg.sv
package exc_seq_pkg;
  localparam logic [31:0] BOOT_ADDR    = 32'hBFC0_0000;
  localparam logic [31:0] REFILL_ENTRY = 32'h8000_0000;
  localparam logic [31:0] COMMON_ENTRY = 32'h8000_0080;
  localparam logic [31:0] STEP         = 32'd4;

  typedef enum logic [3:0] {
    CAUSE_EXT_INT   = 4'd0,
    CAUSE_TLB_MOD   = 4'd1,
    CAUSE_TLB_LD    = 4'd2,
    CAUSE_TLB_ST    = 4'd3,
    CAUSE_ADR_LD    = 4'd4,
    CAUSE_ADR_ST    = 4'd5,
    CAUSE_BUS_FETCH = 4'd6,
    CAUSE_BUS_DATA  = 4'd7,
    CAUSE_SYSCALL   = 4'd8,
    CAUSE_BREAK     = 4'd9,
    CAUSE_RSVD      = 4'd10,
    CAUSE_COP_UNUSE = 4'd11,
    CAUSE_OVERFLOW  = 4'd12
  } cause_e;
endpackage

// File: rtl/exc_sample_tick.sv
// Counts retirements and flags the one completing each group of PERIOD.
module exc_sample_tick #(
  parameter int PERIOD = 64
) (
  input  logic clk,
  input  logic rst,
  input  logic adv,
  output logic due
);
  localparam int CW = (PERIOD > 1) ? $clog2(PERIOD) : 1;
  localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

  logic [CW-1:0] cnt_q;

  assign due = adv && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (rst)         cnt_q <= '0;
    else if (due)    cnt_q <= '0;
    else if (adv)    cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/exc_irq_pick.sv
// Fixed-order scan: the lowest enabled pending source wins.
module exc_irq_pick #(
  parameter int NSRC = 6,
  localparam int IW  = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic [NSRC-1:0] pend,
  input  logic [NSRC-1:0] mask,
  output logic            hit,
  output logic [IW-1:0]   idx
);
  logic [NSRC-1:0] live;
  assign live = pend & mask;
  assign hit  = |live;

  always_comb begin
    idx = '0;
    for (int k = NSRC - 1; k >= 0; k--) begin
      if (live[k]) idx = IW'(k);
    end
  end
endmodule

// File: rtl/exc_pc_seq.sv
module exc_pc_seq
  import exc_seq_pkg::*;
#(
  parameter int NSRC   = 6,
  parameter int PERIOD = 64,
  localparam int IW    = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            retire_i,
  input  logic            br_take_i,
  input  logic [31:0]     br_target_i,
  input  logic            exc_req_i,
  input  logic            exc_refill_i,
  input  logic [3:0]      exc_code_i,
  input  logic [NSRC-1:0] irq_pend_i,
  input  logic [NSRC-1:0] irq_mask_i,
  output logic [31:0]     pc_o,
  output logic [31:0]     npc_o,
  output logic [31:0]     epc_o,
  output logic            bd_o,
  output logic [3:0]      code_o,
  output logic [IW-1:0]   irq_num_o,
  output logic            taken_o
);
  logic [31:0]   pc_q, npc_q, epc_q;
  logic          bd_q, taken_q;
  logic [3:0]    code_q;
  logic [IW-1:0] inum_q;

  logic          counted, poll, irq_hit;
  logic [IW-1:0] irq_idx;

  // A retirement is counted only when no exception replaces it.
  assign counted = retire_i && !exc_req_i;

  exc_sample_tick #(.PERIOD(PERIOD)) u_tick (
    .clk (clk),
    .rst (rst),
    .adv (counted),
    .due (poll)
  );

  exc_irq_pick #(.NSRC(NSRC)) u_pick (
    .pend (irq_pend_i),
    .mask (irq_mask_i),
    .hit  (irq_hit),
    .idx  (irq_idx)
  );

  // Address pair after a normal retirement.
  logic [31:0] adv_pc, adv_npc;
  assign adv_pc  = npc_q;
  assign adv_npc = br_take_i ? br_target_i : (npc_q + STEP);

  logic [31:0] exc_entry;
  assign exc_entry = exc_refill_i ? REFILL_ENTRY : COMMON_ENTRY;

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q    <= BOOT_ADDR;
      npc_q   <= BOOT_ADDR + STEP;
      epc_q   <= '0;
      bd_q    <= 1'b0;
      code_q  <= '0;
      inum_q  <= '0;
      taken_q <= 1'b0;
    end else begin
      taken_q <= 1'b0;
      if (exc_req_i) begin
        epc_q   <= pc_q;
        bd_q    <= (npc_q != pc_q + STEP);
        code_q  <= exc_code_i;
        inum_q  <= '0;
        pc_q    <= exc_entry;
        npc_q   <= exc_entry + STEP;
        taken_q <= 1'b1;
      end else if (poll && irq_hit) begin
        epc_q   <= adv_pc;
        bd_q    <= (adv_npc != adv_pc + STEP);
        code_q  <= CAUSE_EXT_INT;
        inum_q  <= irq_idx;
        pc_q    <= COMMON_ENTRY;
        npc_q   <= COMMON_ENTRY + STEP;
        taken_q <= 1'b1;
      end else if (retire_i) begin
        pc_q  <= adv_pc;
        npc_q <= adv_npc;
      end
    end
  end

  assign pc_o      = pc_q;
  assign npc_o     = npc_q;
  assign epc_o     = epc_q;
  assign bd_o      = bd_q;
  assign code_o    = code_q;
  assign irq_num_o = inum_q;
  assign taken_o   = taken_q;
endmodule

// File: rtl/exc_pc_seq_chk.sv
module exc_pc_seq_chk #(
  parameter int NSRC   = 6,
  parameter int PERIOD = 64,
  localparam int IW    = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input logic            clk,
  input logic            rst,
  input logic            retire_i,
  input logic            br_take_i,
  input logic            exc_req_i,
  input logic            exc_refill_i,
  input logic [NSRC-1:0] irq_pend_i,
  input logic [NSRC-1:0] irq_mask_i,
  input logic [31:0]     pc_o,
  input logic [31:0]     npc_o,
  input logic [31:0]     epc_o,
  input logic            bd_o,
  input logic [3:0]      code_o,
  input logic [IW-1:0]   irq_num_o,
  input logic            taken_o
);
  localparam int CW = (PERIOD > 1) ? $clog2(PERIOD) : 1;

  // Independent poll-window tracker.
  logic [CW-1:0]   seen_q;
  logic            window_q, exc_q;
  logic [NSRC-1:0] live_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      seen_q   <= '0;
      window_q <= 1'b0;
      exc_q    <= 1'b0;
      live_q   <= '0;
    end else begin
      exc_q    <= exc_req_i;
      live_q   <= irq_pend_i & irq_mask_i;
      window_q <= retire_i && !exc_req_i && (int'(seen_q) == PERIOD - 1);
      if (retire_i && !exc_req_i)
        seen_q <= (int'(seen_q) == PERIOD - 1) ? '0 : seen_q + 1'b1;
    end
  end

  logic irq_served;
  assign irq_served = taken_o && !exc_q;

  assert_boot_R1: assert property (@(posedge clk)
    rst |=> (pc_o == 32'hBFC0_0000 && npc_o == 32'hBFC0_0004 && !taken_o));

  assert_refill_entry_R4: assert property (@(posedge clk) disable iff (rst)
    (exc_req_i && exc_refill_i) |=> (pc_o == 32'h8000_0000 && npc_o == 32'h8000_0004));

  assert_common_entry_R4: assert property (@(posedge clk) disable iff (rst)
    (exc_req_i && !exc_refill_i) |=> (pc_o == 32'h8000_0080 && npc_o == 32'h8000_0084));

  assert_saved_pc_R5: assert property (@(posedge clk) disable iff (rst)
    exc_req_i |=> (taken_o && epc_o == $past(pc_o)));

  assert_pulse_R5: assert property (@(posedge clk) disable iff (rst)
    taken_o |=> !taken_o || $past(exc_req_i));

  assert_delay_flag_R6: assert property (@(posedge clk) disable iff (rst)
    exc_req_i |=> (bd_o == ($past(npc_o) != $past(pc_o) + 32'd4)));

  assert_exc_wins_R7: assert property (@(posedge clk) disable iff (rst)
    (exc_req_i && retire_i && br_take_i) |=> (pc_o[31:8] == 24'h800000));

  assert_poll_only_R8: assert property (@(posedge clk) disable iff (rst)
    irq_served |-> window_q);

  assert_lowest_R9: assert property (@(posedge clk) disable iff (rst)
    irq_served |-> (live_q[irq_num_o] &&
                    ((live_q & ((NSRC'(1) << irq_num_o) - NSRC'(1))) == '0) &&
                    code_o == 4'd0 && pc_o == 32'h8000_0080));
endmodule

bind exc_pc_seq exc_pc_seq_chk #(.NSRC(NSRC), .PERIOD(PERIOD)) u_chk (.*);

// File: tb/test_exc_pc_seq.sv
module test_exc_pc_seq;
  localparam int CLK_PERIOD = 10;
  localparam int NSRC = 6;
  localparam int IW = 3;

  logic            clk = 1'b0;
  logic            rst;
  logic            retire_i, br_take_i, exc_req_i, exc_refill_i;
  logic [31:0]     br_target_i;
  logic [3:0]      exc_code_i;
  logic [NSRC-1:0] irq_pend_i, irq_mask_i;
  logic [31:0]     pc_o, npc_o, epc_o;
  logic            bd_o, taken_o;
  logic [3:0]      code_o;
  logic [IW-1:0]   irq_num_o;

  int checks = 0;
  int errors = 0;

  // Bench model
  logic [31:0] m_pc, m_npc, m_epc;
  logic        m_bd, m_taken;
  logic [3:0]  m_code;
  int          m_num;
  int          m_rc;

  always #(CLK_PERIOD/2) clk = ~clk;

  exc_pc_seq #(.NSRC(NSRC), .PERIOD(64)) i_exc_pc_seq (.*);

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic compare(input string req);
    chk(req, "pc", pc_o, m_pc);
    chk(req, "npc", npc_o, m_npc);
    chk(req, "taken", {31'd0, taken_o}, {31'd0, m_taken});
    if (m_taken) begin
      chk(req, "epc", epc_o, m_epc);
      chk(req, "bd", {31'd0, bd_o}, {31'd0, m_bd});
      chk(req, "code", {28'd0, code_o}, {28'd0, m_code});
      if (m_code == 4'd0) chk(req, "irq_num", {29'd0, irq_num_o}, 32'(m_num));
    end
  endtask

  // One cycle: drive at negedge, clock, compare at the following negedge.
  task automatic step(input string req, input logic ret, input logic br, input logic [31:0] tgt,
                      input logic exc, input logic refill, input logic [3:0] code);
    logic [31:0] v, pa;
    logic [NSRC-1:0] live;
    retire_i = ret; br_take_i = br; br_target_i = tgt;
    exc_req_i = exc; exc_refill_i = refill; exc_code_i = code;
    @(posedge clk);
    m_taken = 1'b0;
    live = irq_pend_i & irq_mask_i;
    if (exc) begin
      v = refill ? 32'h8000_0000 : 32'h8000_0080;
      m_epc = m_pc; m_bd = (m_npc != m_pc + 32'd4); m_code = code;
      m_pc = v; m_npc = v + 32'd4; m_taken = 1'b1;
    end else if (ret) begin
      pa = br ? tgt : m_npc + 32'd4;
      m_pc = m_npc; m_npc = pa;
      if (m_rc == 63) begin
        m_rc = 0;
        if (live != '0) begin
          m_num = 0;
          for (int k = NSRC - 1; k >= 0; k--) if (live[k]) m_num = k;
          m_epc = m_pc; m_bd = (m_npc != m_pc + 32'd4); m_code = 4'd0;
          m_pc = 32'h8000_0080; m_npc = 32'h8000_0084; m_taken = 1'b1;
        end
      end else m_rc++;
    end
    @(negedge clk);
    compare(req);
  endtask

  task automatic plain(input string req);
    step(req, 1'b1, 1'b0, 32'd0, 1'b0, 1'b0, 4'd0);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    errors++;
    $display("FAIL watchdog: actual running expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst = 1'b1; retire_i = 0; br_take_i = 0; br_target_i = 0;
    exc_req_i = 0; exc_refill_i = 0; exc_code_i = 0;
    irq_pend_i = '0; irq_mask_i = '0;
    m_pc = 32'hBFC0_0000; m_npc = 32'hBFC0_0004; m_taken = 0; m_rc = 0;
    m_epc = 0; m_bd = 0; m_code = 0; m_num = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    compare("R1");
    // Idle cycle: no change; branch strobe alone is ignored (R3)
    step("R3", 1'b0, 1'b1, 32'h1234_5670, 1'b0, 1'b0, 4'd0);

    for (int i = 0; i < 8; i++) plain("R2");
    // Pending interrupt between polls is ignored (R8)
    irq_pend_i = 6'b000100; irq_mask_i = 6'b111111;
    plain("R8");
    plain("R8");
    irq_pend_i = '0;

    step("R3", 1'b1, 1'b1, 32'h0040_0100, 1'b0, 1'b0, 4'd0);
    plain("R3");
    // Branch then exception in the delay slot: bd set (R6)
    step("R3", 1'b1, 1'b1, 32'h0040_0200, 1'b0, 1'b0, 4'd0);
    step("R6", 1'b0, 1'b0, 32'd0, 1'b1, 1'b0, 4'd12);
    plain("R2");
    // Every cause code, refill entry for the TLB miss codes (R4 R5 R6)
    for (int c = 1; c <= 12; c++) begin
      step("R5", 1'b0, 1'b0, 32'd0, 1'b1, (c == 2 || c == 3), 4'(c));
      plain("R4");
      plain("R6");
    end
    // Exception beats simultaneous retirement and branch (R7)
    step("R7", 1'b1, 1'b1, 32'h0000_4440, 1'b1, 1'b0, 4'd8);
    step("R7", 1'b1, 1'b1, 32'h0000_4480, 1'b1, 1'b1, 4'd2);

    // Poll with several enabled sources: lowest wins (R9, R8)
    irq_pend_i = 6'b101000; irq_mask_i = 6'b111111;
    while (m_rc != 63) plain("R8");
    plain("R9");
    // Poll with only masked sources: no redirection (R9)
    irq_mask_i = 6'b010111;
    while (m_rc != 63) plain("R8");
    plain("R9");
    // Poll on a branching retirement: interrupted address is a delay slot (R9 R6)
    irq_pend_i = 6'b100110; irq_mask_i = 6'b111111;
    while (m_rc != 63) plain("R8");
    step("R9", 1'b1, 1'b1, 32'h0000_9000, 1'b0, 1'b0, 4'd0);
    // Exceptions inside a window do not advance the cadence (R7 R8)
    irq_pend_i = 6'b000001;
    while (m_rc != 60) plain("R8");
    step("R7", 1'b1, 1'b0, 32'd0, 1'b1, 1'b0, 4'd9);
    while (m_rc != 63) plain("R8");
    plain("R9");
    // Reset again mid-stream (R1)
    rst = 1'b1; @(posedge clk); @(negedge clk); rst = 1'b0;
    m_pc = 32'hBFC0_0000; m_npc = 32'hBFC0_0004; m_taken = 0; m_rc = 0;
    compare("R1");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule